// File: doc/BRIEF.md
# Register-Paced I2C Bus Master

This block is an I2C bus master that software runs through four 32-bit registers. To send a byte, software first loads it into the data register. It then writes a mode-and-command code into the status register to open the bus with a START, or with a repeated START if the bus is still held. The controller shifts every byte out or in over nine SCL clocks, the ninth being the acknowledge slot. After each byte it raises a pending flag and holds SCL low until software clears that flag. Clearing the flag lets the next byte, the next START or the STOP go ahead.

A write transaction follows this order: address byte with bit 0 clear, an optional register byte, the data bytes, then STOP. A read with a register index first writes that index. It then issues a repeated START in receive mode, sends the address with bit 0 set and shifts in data bytes. Software acknowledges every received byte except the last. A prescaler divides the system clock to set the SCL period. SCL and SDA are open-drain: each has an output enable that pulls the line low and an input that returns the line's state.

Top module: `i2c_reg_master`

## Requirements
- R1: After reset, the control, status, own-address and data registers all read 0, irq is 0, and both scl_oe and sda_oe are 0 (lines released).
- R2: Registers decode on byte-address bits 3:2. Offset 0x0 is control, 0x4 is status, 0x8 is own address and 0xC is data. Each holds 8 bits that read back zero-extended to 32. Control bit 4 (pending) cannot be set by a write.
- R3: Writing 0xF0 to status (mode bits 7:6 = 11 for transmit, bit 5 = 1 for start) on an idle bus does three things. It produces a START (SDA falls while SCL is high). It sends the data register MSB first on eight SCL clocks. It samples SDA during the ninth clock and stores the result in status bit 0 (1 = no acknowledge).
- R4: Control bit 4 (pending) is set when a byte and its acknowledge slot finish. While it is set, SCL is held low and no further bit is clocked. A control write with bit 4 = 0 clears it. A write with bit 4 = 1 leaves it set.
- R5: Status bit 5 reads 1 from the START until the STOP has completed. Writing 0xD0 or 0x90 (bit 5 = 0) and then clearing pending produces a STOP (SDA rises while SCL is high). After the STOP, both lines are released.
- R6: Writing 0xB0 (mode 10 = receive, bit 5 = 1) while the bus is held, then clearing pending, produces a repeated START. The data register (the address with bit 0 set) is then transmitted.
- R7: In receive mode, every byte after the address byte is shifted in MSB first and loaded into the data register before pending rises. In the ninth clock the master drives SDA low when control bit 7 was 1 and leaves SDA released when it was 0.
- R8: irq equals control bit 5 (interrupt enable) AND pending.
- R9: One quarter of an SCL bit lasts (control[3:0] + 1) * UNIT system clocks. Consecutive SCL rising edges within a byte are therefore 4 * (control[3:0] + 1) * UNIT clocks apart.
- R10: When a device holds SCL low after the master releases it, the master waits. The byte completes correctly once the line is released, and pending stays 0 while the line is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address (bits 3:2 select) |
| reg_wdata | input | 32 | Register write data (bits 7:0 used) |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt: enable AND pending |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_in | input | 1 | Sensed SCL line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA line level |

## Verification
The bench builds the block with UNIT = 2. A quarter bit then lasts 2 to 32 clocks, so every prescaler setting, including the slowest, finishes a whole transaction in a few thousand cycles. The vector table spans several prescaler values with both acknowledge and no-acknowledge devices. The exact SCL spacing is measured against the prescaler formula. A bus model in the bench decodes START, repeated START and STOP, acknowledges or refuses bytes, supplies read data, records the master's acknowledge bits and can hold SCL low to exercise waiting.

// File: rtl/i2c_rm_pkg.sv
package i2c_rm_pkg;
  localparam int REG_AW = 4;
  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_STAT = 2'd1;
  localparam logic [1:0] IDX_OWN  = 2'd2;
  localparam logic [1:0] IDX_DATA = 2'd3;
  localparam logic [1:0] MODE_MTX = 2'b11;

  typedef enum logic [1:0] {
    OP_START  = 2'd0,
    OP_RSTART = 2'd1,
    OP_STOP   = 2'd2,
    OP_BYTE   = 2'd3
  } seq_op_e;

  // clocks per quarter of an SCL bit
  function automatic int unsigned quarter_cycles(input int unsigned pre, input int unsigned unit);
    return (pre + 1) * unit;
  endfunction
endpackage

// File: rtl/i2c_rm_prescaler.sv
module i2c_rm_prescaler #(
  parameter int UNIT  = 8,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  import i2c_rm_pkg::*;
  localparam int CNT_W = $clog2((2**PRE_W) * UNIT + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  always_comb limit = CNT_W'(quarter_cycles(int'(pre), UNIT) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!run || cnt == limit) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == limit);

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n) cnt <= limit || $changed(pre));
endmodule

// File: rtl/i2c_rm_bitseq.sv
module i2c_rm_bitseq #(
  parameter int BYTE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  i2c_rm_pkg::seq_op_e  op,
  input  logic [BYTE_W-1:0]    tx_byte,
  input  logic                 tx_mode,
  input  logic                 ack_en,
  input  logic                 tick,
  input  logic                 scl_in,
  input  logic                 sda_in,
  output logic                 active,
  output logic                 done,
  output logic [BYTE_W-1:0]    rx_byte,
  output logic                 nack,
  output logic                 scl_low,
  output logic                 sda_low
);
  import i2c_rm_pkg::*;
  localparam int BC_W = $clog2(BYTE_W + 1);
  localparam logic [BC_W-1:0] ACK_SLOT = BC_W'(BYTE_W);

  seq_op_e           op_q;
  logic [1:0]        ph;
  logic [BC_W-1:0]   bitn;
  logic [BYTE_W-1:0] sh;
  logic              txm, acke;
  logic              out_bit;
  logic              stall;

  // wait for SCL to really go high before the phase that needs it
  assign stall = (ph == 2'd2) && !scl_in && (op_q != OP_START);

  always_comb begin
    if (bitn == ACK_SLOT) out_bit = txm ? 1'b1 : !acke;
    else                  out_bit = txm ? sh[BYTE_W-1] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; done <= 1'b0; op_q <= OP_START; ph <= 2'd0; bitn <= '0;
      sh <= '0; txm <= 1'b0; acke <= 1'b0; nack <= 1'b0; scl_low <= 1'b0; sda_low <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        active <= 1'b1; op_q <= op; ph <= 2'd0; bitn <= '0;
        sh <= tx_byte; txm <= tx_mode; acke <= ack_en;
      end else if (active && tick && !stall) begin
        ph <= ph + 2'd1;
        unique case (op_q)
          OP_START: begin
            unique case (ph)
              2'd0: begin scl_low <= 1'b0; sda_low <= 1'b0; end
              2'd1: sda_low <= 1'b1;
              2'd2: scl_low <= 1'b1;
              default: begin active <= 1'b0; done <= 1'b1; end
            endcase
          end
          OP_RSTART: begin
            unique case (ph)
              2'd0: sda_low <= 1'b0;
              2'd1: scl_low <= 1'b0;
              2'd2: sda_low <= 1'b1;
              default: begin scl_low <= 1'b1; active <= 1'b0; done <= 1'b1; end
            endcase
          end
          OP_STOP: begin
            unique case (ph)
              2'd0: sda_low <= 1'b1;
              2'd1: scl_low <= 1'b0;
              2'd2: sda_low <= 1'b0;
              default: begin active <= 1'b0; done <= 1'b1; end
            endcase
          end
          default: begin
            unique case (ph)
              2'd0: sda_low <= !out_bit;
              2'd1: scl_low <= 1'b0;
              2'd2: begin
                if (bitn == ACK_SLOT) nack <= sda_in;
                else sh <= {sh[BYTE_W-2:0], sda_in};
              end
              default: begin
                scl_low <= 1'b1;
                if (bitn == ACK_SLOT) begin active <= 1'b0; done <= 1'b1; end
                else bitn <= bitn + 1'b1;
              end
            endcase
          end
        endcase
      end
    end
  end

  assign rx_byte = sh;

  // R3: nine slots per byte, the counter never passes the acknowledge slot
  a_r3_bit_range: assert property (@(posedge clk) disable iff (!rst_n) bitn <= ACK_SLOT);
  // R4: a new operation is only launched on an idle sequencer
  a_r4_go_idle: assert property (@(posedge clk) disable iff (!rst_n) go |-> !active);
endmodule

// File: rtl/i2c_rm_ctrl.sv
module i2c_rm_ctrl #(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           widx,
  input  logic [BYTE_W-1:0]    wdata,
  input  logic                 seq_active,
  input  logic                 seq_done,
  input  logic [BYTE_W-1:0]    seq_rx,
  input  logic                 seq_nack,
  output logic                 go,
  output i2c_rm_pkg::seq_op_e  op,
  output logic [BYTE_W-1:0]    tx_byte,
  output logic                 tx_mode,
  output logic                 ack_en,
  output logic [PRE_W-1:0]     pre,
  output logic                 pending,
  output logic                 bus_busy,
  output logic                 irq,
  output logic [BYTE_W-1:0]    ctrl_rd,
  output logic [BYTE_W-1:0]    stat_rd,
  output logic [BYTE_W-1:0]    own_q,
  output logic [BYTE_W-1:0]    data_q
);
  import i2c_rm_pkg::*;

  logic       irq_en, nack_q, cmd_start, cmd_stop, addr_next;
  logic [1:0] mode;
  logic       can_issue;

  assign can_issue = !seq_active && !go && !seq_done && !pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go <= 1'b0; op <= OP_START; tx_byte <= '0; tx_mode <= 1'b0;
      ack_en <= 1'b0; irq_en <= 1'b0; pre <= '0; pending <= 1'b0;
      bus_busy <= 1'b0; nack_q <= 1'b0; mode <= 2'b00; own_q <= '0; data_q <= '0;
      cmd_start <= 1'b0; cmd_stop <= 1'b0; addr_next <= 1'b0;
    end else begin
      go <= 1'b0;
      if (wr_en) begin
        unique case (widx)
          IDX_CTRL: begin
            ack_en <= wdata[7]; irq_en <= wdata[5]; pre <= wdata[PRE_W-1:0];
            if (!wdata[4]) pending <= 1'b0;
          end
          IDX_STAT: begin
            mode <= wdata[7:6];
            if (wdata[5]) cmd_start <= 1'b1;
            else if (bus_busy) cmd_stop <= 1'b1;
          end
          IDX_OWN:  own_q  <= wdata;
          default:  data_q <= wdata;
        endcase
      end
      if (seq_done) begin
        unique case (op)
          OP_BYTE: begin
            pending <= 1'b1; addr_next <= 1'b0;
            if (tx_mode) nack_q <= seq_nack;
            else data_q <= seq_rx;
          end
          OP_STOP: bus_busy <= 1'b0;
          default: ;
        endcase
      end else if (can_issue) begin
        if (cmd_start) begin
          go <= 1'b1; op <= bus_busy ? OP_RSTART : OP_START;
          bus_busy <= 1'b1; cmd_start <= 1'b0; addr_next <= 1'b1;
        end else if (cmd_stop) begin
          go <= 1'b1; op <= OP_STOP; cmd_stop <= 1'b0;
        end else if (bus_busy) begin
          go <= 1'b1; op <= OP_BYTE; tx_byte <= data_q;
          tx_mode <= (mode == MODE_MTX) || addr_next;
        end
      end
    end
  end

  assign irq     = irq_en && pending;
  assign ctrl_rd = {ack_en, 1'b0, irq_en, pending, pre};
  assign stat_rd = {mode, bus_busy, 4'b0000, nack_q};

  // R5: the busy flag drops only when the sequencer reports a finished operation
  a_r5_busy_drop: assert property (@(posedge clk) disable iff (!rst_n) $fell(bus_busy) |-> $past(seq_done));
  // R4: pending rises only at the end of a byte
  a_r4_pending_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(seq_done && op == OP_BYTE));
endmodule

// File: rtl/i2c_reg_master.sv
module i2c_reg_master #(
  parameter int UNIT   = 8,
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq,
  output logic              scl_oe,
  input  logic              scl_in,
  output logic              sda_oe,
  input  logic              sda_in
);
  import i2c_rm_pkg::*;

  logic              go, seq_active, seq_done, seq_nack, tx_mode, ack_en, pending, bus_busy, tick;
  logic              scl_low, sda_low;
  seq_op_e           op;
  logic [BYTE_W-1:0] tx_byte, seq_rx, ctrl_rd, stat_rd, own_q, data_q;
  logic [PRE_W-1:0]  pre;
  logic [1:0]        widx;
  logic              unused_bits;

  assign widx        = reg_addr[3:2];
  assign unused_bits = ^{reg_addr[1:0], reg_wdata[WORD_W-1:BYTE_W]};

  function automatic logic [WORD_W-1:0] rd_word(input logic [1:0] idx, input logic [BYTE_W-1:0] c,
                                                input logic [BYTE_W-1:0] s, input logic [BYTE_W-1:0] o,
                                                input logic [BYTE_W-1:0] d);
    logic [BYTE_W-1:0] v;
    unique case (idx)
      IDX_CTRL: v = c;
      IDX_STAT: v = s;
      IDX_OWN:  v = o;
      default:  v = d;
    endcase
    return {{(WORD_W-BYTE_W){1'b0}}, v};
  endfunction

  assign reg_rdata = rd_word(widx, ctrl_rd, stat_rd, own_q, data_q);

  i2c_rm_ctrl #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .widx(widx), .wdata(reg_wdata[BYTE_W-1:0]),
    .seq_active(seq_active), .seq_done(seq_done), .seq_rx(seq_rx), .seq_nack(seq_nack),
    .go(go), .op(op), .tx_byte(tx_byte), .tx_mode(tx_mode), .ack_en(ack_en), .pre(pre),
    .pending(pending), .bus_busy(bus_busy), .irq(irq), .ctrl_rd(ctrl_rd), .stat_rd(stat_rd),
    .own_q(own_q), .data_q(data_q)
  );

  i2c_rm_prescaler #(.UNIT(UNIT), .PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(seq_active), .pre(pre), .tick(tick)
  );

  i2c_rm_bitseq #(.BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .op(op), .tx_byte(tx_byte), .tx_mode(tx_mode),
    .ack_en(ack_en), .tick(tick), .scl_in(scl_in), .sda_in(sda_in), .active(seq_active),
    .done(seq_done), .rx_byte(seq_rx), .nack(seq_nack), .scl_low(scl_low), .sda_low(sda_low)
  );

  assign scl_oe = scl_low;
  assign sda_oe = sda_low;

  // R4: the bus is stretched and no bit is clocked while pending is set
  a_r4_stretch: assert property (@(posedge clk) disable iff (!rst_n) pending |-> scl_oe);
  a_r4_no_shift: assert property (@(posedge clk) disable iff (!rst_n) pending |-> !seq_active);
  // R5: both lines are free once the STOP has finished
  a_r5_released: assert property (@(posedge clk) disable iff (!rst_n) $fell(bus_busy) |-> (!scl_oe && !sda_oe));
  // R8: an interrupt always has a pending byte behind it
  a_r8_irq_pending: assert property (@(posedge clk) disable iff (!rst_n) irq |-> pending);
endmodule

// File: tb/i2c_reg_master_tb.sv
module i2c_reg_master_tb;
  localparam int UNIT = 2;
  localparam int NV = 4;
  // {prescale, address byte, data byte, device acknowledges}
  localparam logic [20:0] VEC [0:NV-1] = '{
    {4'd0, 8'h3A, 8'h5C, 1'b1},
    {4'd3, 8'h50, 8'hA5, 1'b1},
    {4'd7, 8'h7E, 8'h01, 1'b1},
    {4'd1, 8'h22, 8'hFF, 1'b0}
  };

  logic        clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = 32'h0, reg_rdata;
  logic        irq, scl_oe, sda_oe, scl_line, sda_line;
  logic        slv_hold = 1'b0, slv_sda = 1'b0;
  int          compared = 0, mismatched = 0, cyc = 0;

  assign scl_line = !scl_oe && !slv_hold;
  assign sda_line = !sda_oe && !slv_sda;

  i2c_reg_master #(.UNIT(UNIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .scl_oe(scl_oe), .scl_in(scl_line),
    .sda_oe(sda_oe), .sda_in(sda_line)
  );

  always #10 clk = !clk;
  always @(posedge clk) cyc <= cyc + 1;

  // bus device model
  int         sbit = -1, wn = 0, starts = 0, stops = 0, rdi = 0, scl_per = 0, last_rise = 0;
  logic [7:0] ssh = 8'h00;
  logic [7:0] wlog [0:15];
  logic [7:0] rdq [0:3];
  logic       sfirst = 1'b0, srd = 1'b0, sinrd = 1'b0, smack = 1'b1, sack_cfg = 1'b1;
  logic       p_scl = 1'b1, p_sda = 1'b1;

  always @(scl_line or sda_line) begin
    if (scl_line && p_scl && p_sda && !sda_line) begin
      starts++; sbit = -1; sfirst = 1'b1; srd = 1'b0; sinrd = 1'b0; smack = 1'b1; slv_sda = 1'b0;
    end else if (scl_line && p_scl && !p_sda && sda_line) begin
      stops++;
    end else if (scl_line && !p_scl) begin
      if (sbit >= 1 && sbit <= 8) scl_per = cyc - last_rise;
      last_rise = cyc;
      if (sbit >= 0 && sbit < 8) ssh = {ssh[6:0], sda_line};
      else if (sbit == 8 && sinrd) begin smack = !sda_line; rdi = (rdi + 1) % 4; end
    end else if (!scl_line && p_scl) begin
      sbit = (sbit == 8) ? 0 : sbit + 1;
      slv_sda = 1'b0;
      if (sbit == 8 && !sinrd) begin
        if (wn < 16) begin wlog[wn] = ssh; wn++; end
        if (sfirst) begin srd = ssh[0]; sfirst = 1'b0; end
        slv_sda = sack_cfg;
      end else if (sbit == 0 && srd) sinrd = 1'b1;
      if (sinrd && smack && sbit >= 0 && sbit < 8) slv_sda = !rdq[rdi][7-sbit];
    end
    p_scl = scl_line; p_sda = sda_line;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr_t(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_rd_t(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_bit(input logic [3:0] a, input int b, input logic val, input string tag);
    logic [31:0] v;
    int n = 0;
    reg_rd_t(a, v);
    while (v[b] !== val && n < 20000) begin reg_rd_t(a, v); n++; end
    if (n >= 20000) check({tag, " timeout"}, 32'(v[b]), 32'(val));
  endtask

  initial begin
    #(200000 * 20);
    mismatched++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int s0, t0;
    rdq[0] = 8'h9D; rdq[1] = 8'h42; rdq[2] = 8'h00; rdq[3] = 8'h00;
    for (int i = 0; i < 16; i++) wlog[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_rd_t(4'h0, v); check("R1 ctrl", v, 0);
    reg_rd_t(4'h4, v); check("R1 status", v, 0);
    reg_rd_t(4'h8, v); check("R1 own", v, 0);
    reg_rd_t(4'hC, v); check("R1 data", v, 0);
    check("R1 irq/lines", {29'd0, irq, scl_oe, sda_oe}, 0);

    // R2 register map
    reg_wr_t(4'h8, 32'hFFFF_FF5A); reg_rd_t(4'h8, v); check("R2 own", v, 32'h5A);
    reg_wr_t(4'hC, 32'h0000_00C3); reg_rd_t(4'hC, v); check("R2 data", v, 32'hC3);
    reg_wr_t(4'h0, 32'h0000_00B3); reg_rd_t(4'h0, v); check("R2 ctrl no pending set", v, 32'hA3);
    check("R8 irq off without pending", 32'(irq), 0);

    // vector table: address + data write, then STOP
    for (int k = 0; k < NV; k++) begin
      logic [3:0] pre; logic [7:0] ad, dt; logic ackc;
      {pre, ad, dt, ackc} = VEC[k];
      sack_cfg = ackc; wn = 0;
      reg_wr_t(4'h0, {28'd0, pre});
      reg_wr_t(4'hC, {24'd0, ad});
      reg_wr_t(4'h4, 32'hF0);
      wait_bit(4'h0, 4, 1'b1, "R4 pending");
      reg_rd_t(4'h4, v);
      check("R3 nack bit", 32'(v[0]), 32'(!ackc));
      check("R5 busy mid", 32'(v[5]), 1);
      check("R9 scl period", scl_per, 4 * (pre + 1) * UNIT);
      reg_wr_t(4'hC, {24'd0, dt});
      reg_wr_t(4'h0, {28'd0, pre});
      wait_bit(4'h0, 4, 1'b1, "R4 pending");
      s0 = stops;
      reg_wr_t(4'h4, 32'hD0);
      reg_wr_t(4'h0, {28'd0, pre});
      wait_bit(4'h4, 5, 1'b0, "R5 busy");
      check("R3 addr byte", {24'd0, wlog[0]}, {24'd0, ad});
      check("R3 data byte", {24'd0, wlog[1]}, {24'd0, dt});
      check("R3 byte count", wn, 2);
      check("R5 stop seen", stops - s0, 1);
      check("R5 lines released", {30'd0, scl_oe, sda_oe}, 0);
    end

    // R4 / R8 pending holds the bus
    sack_cfg = 1'b1; wn = 0;
    reg_wr_t(4'h0, 32'h21);
    reg_wr_t(4'hC, 32'h3A);
    reg_wr_t(4'h4, 32'hF0);
    wait_bit(4'h0, 4, 1'b1, "R4 pending");
    check("R8 irq with pending", 32'(irq), 1);
    repeat (300) @(negedge clk);
    reg_rd_t(4'h0, v);
    check("R4 still pending", 32'(v[4]), 1);
    check("R4 scl held low", 32'(scl_oe), 1);
    check("R4 no extra byte", wn, 1);
    reg_wr_t(4'h0, 32'h31);
    reg_rd_t(4'h0, v);
    check("R4 bit4=1 keeps pending", 32'(v[4]), 1);
    reg_wr_t(4'hC, 32'h66);
    reg_wr_t(4'h0, 32'h01);
    check("R8 irq off after clear", 32'(irq), 0);
    wait_bit(4'h0, 4, 1'b1, "R4 pending");
    check("R4 next byte sent", {24'd0, wlog[1]}, 32'h66);
    reg_wr_t(4'h4, 32'hD0);
    reg_wr_t(4'h0, 32'h01);
    wait_bit(4'h4, 5, 1'b0, "R5 busy");

    // R6 / R7 register read with repeated START
    wn = 0; s0 = starts; t0 = stops; rdi = 0;
    reg_wr_t(4'h0, 32'h82);
    reg_wr_t(4'hC, 32'h3A);
    reg_wr_t(4'h4, 32'hF0);
    wait_bit(4'h0, 4, 1'b1, "R4 pending");
    reg_wr_t(4'hC, 32'h29);
    reg_wr_t(4'h0, 32'h82);
    wait_bit(4'h0, 4, 1'b1, "R4 pending");
    reg_wr_t(4'hC, 32'h3B);
    reg_wr_t(4'h4, 32'hB0);
    reg_wr_t(4'h0, 32'h82);
    wait_bit(4'h0, 4, 1'b1, "R4 pending");
    check("R6 repeated start", starts - s0, 2);
    check("R6 bytes on bus", {8'd0, wlog[0], wlog[1], wlog[2]}, 32'h003A293B);
    reg_rd_t(4'h4, v); check("R6 still busy", 32'(v[5]), 1);
    reg_wr_t(4'h0, 32'h82);
    wait_bit(4'h0, 4, 1'b1, "R4 pending");
    reg_rd_t(4'hC, v); check("R7 first rx byte", v, 32'h9D);
    check("R7 ack driven", 32'(smack), 1);
    reg_wr_t(4'h0, 32'h02);
    wait_bit(4'h0, 4, 1'b1, "R4 pending");
    reg_rd_t(4'hC, v); check("R7 last rx byte", v, 32'h42);
    check("R7 nack released", 32'(smack), 0);
    reg_wr_t(4'h4, 32'h90);
    reg_wr_t(4'h0, 32'h02);
    wait_bit(4'h4, 5, 1'b0, "R5 busy");
    check("R5 rx stop", stops - t0, 1);

    // R10 device holds SCL
    wn = 0;
    reg_wr_t(4'h0, 32'h00);
    reg_wr_t(4'hC, 32'h3A);
    reg_wr_t(4'h4, 32'hF0);
    repeat (20) @(negedge clk);
    while (!scl_oe) @(negedge clk);
    slv_hold = 1'b1;
    repeat (150) @(negedge clk);
    reg_rd_t(4'h0, v);
    check("R10 waits while held", 32'(v[4]), 0);
    slv_hold = 1'b0;
    wait_bit(4'h0, 4, 1'b1, "R10 pending");
    check("R10 byte intact", {24'd0, wlog[0]}, 32'h3A);
    reg_wr_t(4'h4, 32'hD0);
    reg_wr_t(4'h0, 32'h00);
    wait_bit(4'h4, 5, 1'b0, "R5 busy");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule